// File: doc/BRIEF.md
# Double-Buffered Configuration Plane Controller

This block keeps two complete copies of the configuration for a reconfigurable datapath array. One copy, the active plane, drives the whole fabric through a wide parallel output bus. The other copy, the background plane, is filled one word at a time through a valid/ready write port while the active plane keeps running. The fabric always runs exactly one configuration; it is never split between two.

Once the background plane holds a full configuration, a swap request exchanges the roles of the two planes on a single clock edge. The new configuration reaches the fabric the next cycle without stalling it. The plane that was active becomes the new background plane and takes the next configuration. Configurations therefore follow one another in a chain: one runs while the next one loads.

A swap request that arrives before the background plane is complete is refused. The refusal is recorded in a sticky error flag.

Top module: `cfgp_dbuf_top`

## Requirements
- R1: After reset, `active_sel` is 0, `cfg_active` is all zeros, `bg_full` is 0, `swap_err` is 0 and `wr_ready` is 1.
- R2: Accepted writes (`wr_valid` and `wr_ready` both high at a rising edge) fill the background plane in arrival order. The k-th accepted word, counting from 0, appears at bits [k*WORD_W +: WORD_W] of `cfg_active` once that plane is made active.
- R3: `cfg_active` and `active_sel` change only in the cycle after an accepted swap. Writes to the background plane never disturb them.
- R4: `bg_full` rises in the cycle after the N_WORDS-th accepted write. It stays high until a swap is accepted. `wr_ready` is low whenever `bg_full` is high, which includes the swap cycle itself.
- R5: A write offered while `wr_ready` is low has no effect on the stored configuration.
- R6: A swap is accepted when `swap_req` is high at an edge while `bg_full` is already high. In the next cycle `active_sel` has toggled, `cfg_active` shows the newly loaded plane, `bg_full` is 0 and `wr_ready` is 1.
- R7: A swap request made while `bg_full` is low is ignored and sets `swap_err` in the next cycle. Only reset clears `swap_err` again.
- R8: After a swap, the formerly active plane is the background plane and loads from word 0. A second swap brings `active_sel` back to 0 with the newly written words.
- R9: The completeness check for a swap uses the state of `bg_full` before the edge. A swap request in the same cycle as the last write is therefore refused, and a refused swap does not reset the load position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, deasserts synchronously (synchronized upstream) |
| wr_valid | input | 1 | A configuration word is offered |
| wr_data | input | WORD_W | Configuration word |
| wr_ready | output | 1 | The background plane can take a word |
| swap_req | input | 1 | Request to exchange the active and background planes |
| active_sel | output | 1 | Index of the plane that currently drives the fabric |
| bg_full | output | 1 | The background plane holds a complete configuration |
| swap_err | output | 1 | Sticky: a swap was requested before the background plane was complete |
| cfg_active | output | N_WORDS*WORD_W | Configuration bits of the active plane |

## Verification
On every cycle, the assertions check the following: the active output and the plane select hold still unless a swap was accepted, every accepted swap toggles the select and empties the background plane, the write port is closed while the background plane is full, and the error flag rises after a refused swap and then stays set. The bench scenarios cover what a property over ports cannot see. These are the word ordering inside the loaded configuration, the words dropped while the port is closed, a refused swap that leaves the load position where it was, the last write and a swap landing in the same cycle, and a chain of configurations running through both planes in turn.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_N_WORDS = 8;
  localparam int unsigned NUM_PLANES  = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfgp_load_ctrl.sv
`timescale 1ns/1ps
module cfgp_load_ctrl
  import cfgp_pkg::*;
#(
  parameter int unsigned N_WORDS = DEF_N_WORDS,
  localparam int unsigned IDX_W  = idx_width(N_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             swap_go,
  output logic             wr_ready,
  output logic             wr_fire,
  output logic [IDX_W-1:0] wr_idx,
  output logic             bg_full
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             full_q, full_d;
  logic             st_en;

  assign wr_ready = ~full_q;
  assign wr_fire  = wr_valid & wr_ready;
  assign wr_idx   = idx_q;
  assign bg_full  = full_q;
  assign st_en    = wr_fire | swap_go;

  always_comb begin
    idx_d  = idx_q;
    full_d = full_q;
    if (swap_go) begin
      idx_d  = '0;
      full_d = 1'b0;
    end else if (wr_fire) begin
      if (idx_q == LAST_IDX) begin
        idx_d  = '0;
        full_d = 1'b1;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (st_en) begin
      idx_q  <= idx_d;
      full_q <= full_d;
    end
  end
endmodule

// File: rtl/cfgp_swap_ctrl.sv
`timescale 1ns/1ps
module cfgp_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic bg_full,
  output logic swap_go,
  output logic active_sel,
  output logic swap_err
);
  logic sel_q, sel_d;
  logic err_q, err_d;
  logic refuse;

  assign swap_go    = swap_req & bg_full;
  assign refuse     = swap_req & ~bg_full;
  assign active_sel = sel_q;
  assign swap_err   = err_q;

  always_comb begin
    sel_d = sel_q;
    err_d = err_q;
    if (swap_go) sel_d = ~sel_q;
    if (refuse)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (swap_go) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (refuse) begin
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/cfgp_plane_store.sv
`timescale 1ns/1ps
module cfgp_plane_store
  import cfgp_pkg::*;
#(
  parameter int unsigned N_WORDS = DEF_N_WORDS,
  parameter int unsigned WORD_W  = DEF_WORD_W,
  localparam int unsigned IDX_W  = idx_width(N_WORDS),
  localparam int unsigned CFG_W  = N_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              active_sel,
  output logic [CFG_W-1:0]  cfg_active
);
  logic [CFG_W-1:0] plane_q [NUM_PLANES];

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic is_bg;
    assign is_bg = (active_sel != p[0]);
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic              w_en;
      logic [WORD_W-1:0] w_d;
      assign w_en = wr_fire & is_bg & (wr_idx == IDX_W'(w));
      assign w_d  = wr_data;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          plane_q[p][w*WORD_W +: WORD_W] <= '0;
        end else if (w_en) begin
          plane_q[p][w*WORD_W +: WORD_W] <= w_d;
        end
      end
    end
  end

  assign cfg_active = active_sel ? plane_q[1] : plane_q[0];
endmodule

// File: rtl/cfgp_dbuf_top.sv
`timescale 1ns/1ps
module cfgp_dbuf_top
  import cfgp_pkg::*;
#(
  parameter int unsigned N_WORDS = DEF_N_WORDS,
  parameter int unsigned WORD_W  = DEF_WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [WORD_W-1:0]         wr_data,
  output logic                      wr_ready,
  input  logic                      swap_req,
  output logic                      active_sel,
  output logic                      bg_full,
  output logic                      swap_err,
  output logic [N_WORDS*WORD_W-1:0] cfg_active
);
  localparam int unsigned IDX_W = idx_width(N_WORDS);

  logic             swap_go;
  logic             wr_fire;
  logic [IDX_W-1:0] wr_idx;

  cfgp_load_ctrl #(.N_WORDS(N_WORDS)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .swap_go  (swap_go),
    .wr_ready (wr_ready),
    .wr_fire  (wr_fire),
    .wr_idx   (wr_idx),
    .bg_full  (bg_full)
  );

  cfgp_swap_ctrl u_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap_req   (swap_req),
    .bg_full    (bg_full),
    .swap_go    (swap_go),
    .active_sel (active_sel),
    .swap_err   (swap_err)
  );

  cfgp_plane_store #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .active_sel (active_sel),
    .cfg_active (cfg_active)
  );
endmodule

// File: rtl/cfgp_dbuf_chk.sv
`timescale 1ns/1ps
module cfgp_dbuf_chk #(
  parameter int unsigned N_WORDS = 8,
  parameter int unsigned WORD_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_ready,
  input logic                      swap_req,
  input logic                      active_sel,
  input logic                      bg_full,
  input logic                      swap_err,
  input logic [N_WORDS*WORD_W-1:0] cfg_active
);
  p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_req && bg_full) |=> ($stable(cfg_active) && $stable(active_sel)));

  p_closed_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bg_full |-> !wr_ready);

  p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_full && !swap_req) |=> bg_full);

  p_swap_toggles_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && bg_full) |=> ((active_sel != $past(active_sel)) && !bg_full && wr_ready));

  p_refuse_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && !bg_full) |=> swap_err);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_err |=> swap_err);
endmodule

bind cfgp_dbuf_top cfgp_dbuf_chk #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ready   (wr_ready),
  .swap_req   (swap_req),
  .active_sel (active_sel),
  .bg_full    (bg_full),
  .swap_err   (swap_err),
  .cfg_active (cfg_active)
);

// File: tb/sim_cfgp_dbuf_top.sv
`timescale 1ns/1ps
module sim_cfgp_dbuf_top;
  localparam int NW = 4;
  localparam int WW = 32;
  localparam int CW = NW * WW;

  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_WR   = 2'd1;
  localparam logic [1:0] OP_SWAP = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] data;
    logic        e_sel;
    logic        e_full;
    logic        e_err;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{OP_WR,   32'h1111_0000, 1'b0, 1'b0, 1'b0},
    '{OP_WR,   32'h1111_0001, 1'b0, 1'b0, 1'b0},
    '{OP_WR,   32'h1111_0002, 1'b0, 1'b0, 1'b0},
    '{OP_SWAP, 32'h0,         1'b0, 1'b0, 1'b1},
    '{OP_WR,   32'h1111_0003, 1'b0, 1'b1, 1'b1},
    '{OP_WR,   32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1},
    '{OP_SWAP, 32'h0,         1'b1, 1'b0, 1'b1},
    '{OP_WR,   32'h2222_0000, 1'b1, 1'b0, 1'b1},
    '{OP_WR,   32'h2222_0001, 1'b1, 1'b0, 1'b1},
    '{OP_WR,   32'h2222_0002, 1'b1, 1'b0, 1'b1},
    '{OP_WR,   32'h2222_0003, 1'b1, 1'b1, 1'b1},
    '{OP_SWAP, 32'h0,         1'b0, 1'b0, 1'b1},
    '{OP_IDLE, 32'h0,         1'b0, 1'b0, 1'b1}
  };

  logic          clk;
  logic          rst_n;
  logic          wr_valid;
  logic [WW-1:0] wr_data;
  logic          wr_ready;
  logic          swap_req;
  logic          active_sel;
  logic          bg_full;
  logic          swap_err;
  logic [CW-1:0] cfg_active;

  int n_chk;
  int n_bad;
  bit finished;

  cfgp_dbuf_top #(.N_WORDS(NW), .WORD_W(WW)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .swap_req   (swap_req),
    .active_sel (active_sel),
    .bg_full    (bg_full),
    .swap_err   (swap_err),
    .cfg_active (cfg_active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    wr_valid = (op == OP_WR) || (op == 2'd3);
    swap_req = (op == OP_SWAP) || (op == 2'd3);
    wr_data  = d;
    @(posedge clk);
    #2;
    wr_valid = 1'b0;
    swap_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_valid = 1'b0;
    swap_req = 1'b0;
    wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic chk_reset_state();
    chk("R1 active_sel", CW'(active_sel), '0);
    chk("R1 cfg_active", cfg_active, '0);
    chk("R1 bg_full", CW'(bg_full), '0);
    chk("R1 swap_err", CW'(swap_err), '0);
    chk("R1 wr_ready", CW'(wr_ready), CW'(1));
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [CW-1:0] shadow;
    logic [CW-1:0] exp_act;
    int            ld;
    logic          m_full;
    n_chk = 0;
    n_bad = 0;
    finished = 0;
    do_reset();
    chk_reset_state();

    // Table walk: R2 ordering, R3 stability, R4 full, R5 ignored write,
    // R6 swap, R7 refused swap, R8 chain, R9 load position kept.
    shadow = '0;
    exp_act = '0;
    ld = 0;
    m_full = 1'b0;
    for (int i = 0; i < NV; i++) begin
      chk("R4 wr_ready before step", CW'(wr_ready), CW'(!m_full));
      step(TBL[i].op, TBL[i].data);
      if (TBL[i].op == OP_WR && !m_full) begin
        shadow[ld*WW +: WW] = TBL[i].data;
        ld++;
        if (ld == NW) begin
          m_full = 1'b1;
          ld = 0;
        end
      end else if (TBL[i].op == OP_SWAP && m_full) begin
        exp_act = shadow;
        m_full = 1'b0;
      end
      chk("R6 active_sel", CW'(active_sel), CW'(TBL[i].e_sel));
      chk("R4 bg_full", CW'(bg_full), CW'(TBL[i].e_full));
      chk("R7 swap_err", CW'(swap_err), CW'(TBL[i].e_err));
      chk("R2 R3 R5 cfg_active", cfg_active, exp_act);
    end
    chk("R8 back on plane 0", CW'(active_sel), '0);
    chk("R8 second config", cfg_active,
        {32'h2222_0003, 32'h2222_0002, 32'h2222_0001, 32'h2222_0000});

    // R1: reset again in the middle of operation
    do_reset();
    chk_reset_state();

    // R9: last write and swap in the same cycle -> swap refused
    step(OP_WR, 32'hC000_0000);
    step(OP_WR, 32'hC000_0001);
    step(OP_WR, 32'hC000_0002);
    step(2'd3,  32'hC000_0003);
    chk("R9 swap refused same cycle sel", CW'(active_sel), '0);
    chk("R9 swap_err set", CW'(swap_err), CW'(1));
    chk("R9 last word taken", CW'(bg_full), CW'(1));
    chk("R9 fabric untouched", cfg_active, '0);
    chk("R4 ready low when full", CW'(wr_ready), '0);

    // R6: swap now accepted
    step(OP_SWAP, 32'h0);
    chk("R6 sel toggled", CW'(active_sel), CW'(1));
    chk("R6 new config", cfg_active,
        {32'hC000_0003, 32'hC000_0002, 32'hC000_0001, 32'hC000_0000});
    chk("R6 bg_full cleared", CW'(bg_full), '0);
    chk("R6 ready back", CW'(wr_ready), CW'(1));

    // R8/R3: reload old plane, fabric keeps running C
    step(OP_WR, 32'hD000_0000);
    step(OP_WR, 32'hD000_0001);
    chk("R3 stable during load", cfg_active,
        {32'hC000_0003, 32'hC000_0002, 32'hC000_0001, 32'hC000_0000});
    step(OP_WR, 32'hD000_0002);
    step(OP_WR, 32'hD000_0003);
    step(OP_IDLE, 32'h0);
    chk("R4 full held while idle", CW'(bg_full), CW'(1));
    step(OP_SWAP, 32'h0);
    chk("R8 sel back to 0", CW'(active_sel), '0);
    chk("R8 reloaded plane", cfg_active,
        {32'hD000_0003, 32'hD000_0002, 32'hD000_0001, 32'hD000_0000});
    chk("R7 err still sticky", CW'(swap_err), CW'(1));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule